// File: doc/BRIEF.md
# Keyed Software Reset Bank

This block holds a bank of reset lines for on-chip subsystems. Software controls them through a 32-bit register port. Each line has one bit in a line-control register. Writing 1 to the bit asserts the line and writing 0 releases it.

Every write must carry an unlock byte in bits 31:24. A write without that byte changes nothing.

A build option adds a grant register, also one bit per line. A line can only be driven while its grant bit is set. The intended order is:
1. Grant the line.
2. Assert the line.
3. Release the line.
4. Withdraw the grant.

The number of lines is a parameter, up to 24. The reset outputs come straight from flip-flops.

Top module: `keyed_reset_bank`

## Requirements
- R1: After reset, every reset output is low (released), and both the line-control register and the grant register read as zero.
- R2: A write to offset 0x18 with bits 31:24 equal to 0x88 loads bits NUM_LINES-1:0 into the line-control register. Line i is asserted (output high) while its bit i is 1.
- R3: A write whose bits 31:24 differ from 0x88 leaves the line-control register, the grant register and the outputs unchanged.
- R4: With the grant option on, the grant register sits at offset 0xfc and takes keyed writes the same way. Output i is high only when both line-control bit i and grant bit i are 1.
- R5: Clearing a grant bit releases that line even while its line-control bit stays 1. Reading the line-control register still returns the stored 1.
- R6: An output changes only on the clock edge that accepts a keyed write. While the write is presented before that edge, the output keeps its old value.
- R7: Reads return zero in bits 31:24 and in every bit at or above NUM_LINES. Data written into those bits is discarded.
- R8: Any offset other than 0x18 and 0xfc reads as zero. A keyed write to such an offset has no effect.
- R9: With the grant option off, offset 0xfc reads as zero and each output follows its line-control bit directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data; bits 31:24 carry the key |
| rdata | output | 32 | Combinational read data for addr |
| rst_out | output | NUM_LINES | Active-high reset lines |

## Verification
The bench asserts a line before its grant exists and expects it to stay low. It then withdraws one grant while the line-control bit stays set. A design that ignored the grant, or that cleared the stored bit, would show the wrong output or the wrong readback.

Writes with wrong keys go to both registers. A design that checked the key for only one register would change the other.

The bench samples the output while a write is still pending, to catch outputs that change combinationally. A second instance is built with 16 lines and no grant register. It catches readback that leaks bits above the line count, and a grant register that appears when the option is off.

// File: rtl/krb_pkg.sv
package krb_pkg;
  localparam int DATA_W  = 32;
  localparam int KEY_LSB = 24;
  localparam int KEY_W   = 8;

  // Unlock test on the top byte of a write word
  function automatic logic key_match(input logic [DATA_W-1:0] w,
                                     input logic [KEY_W-1:0] key);
    return w[DATA_W-1:KEY_LSB] == key;
  endfunction

  // Effective drive level of one line
  function automatic logic line_level(input logic ctrl_bit,
                                      input logic grant_bit,
                                      input logic has_grant);
    return has_grant ? (ctrl_bit & grant_bit) : ctrl_bit;
  endfunction
endpackage

// File: rtl/krb_decode.sv
module krb_decode
  import krb_pkg::*;
#(
  parameter int ADDR_W              = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h18,
  parameter logic [ADDR_W-1:0] GRANT_OFS = 8'hfc,
  parameter bit HAS_GRANT           = 1'b1,
  parameter logic [KEY_W-1:0] KEY   = 8'h88
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_ctrl,
  output logic              sel_grant,
  output logic              ctrl_we,
  output logic              grant_we
);
  logic unlocked;

  always_comb begin
    unlocked  = key_match(wdata, KEY);
    sel_ctrl  = (addr == CTRL_OFS);
    sel_grant = HAS_GRANT && (addr == GRANT_OFS);
    ctrl_we   = wr_en && unlocked && sel_ctrl;
    grant_we  = wr_en && unlocked && sel_grant;
  end
endmodule

// File: rtl/krb_lines.sv
module krb_lines
  import krb_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter bit HAS_GRANT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic                 grant_we,
  input  logic [NUM_LINES-1:0] wr_bits,
  output logic [NUM_LINES-1:0] ctrl_q,
  output logic [NUM_LINES-1:0] grant_q,
  output logic [NUM_LINES-1:0] rst_out
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic c_nxt;
    logic g_nxt;

    always_comb c_nxt = ctrl_we ? wr_bits[i] : ctrl_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[i] <= 1'b0;
      else        ctrl_q[i] <= c_nxt;
    end

    if (HAS_GRANT) begin : g_gated
      always_comb g_nxt = grant_we ? wr_bits[i] : grant_q[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant_q[i] <= 1'b0;
        else        grant_q[i] <= g_nxt;
      end
    end else begin : g_direct
      always_comb g_nxt = 1'b0;
      always_comb grant_q[i] = 1'b0;
    end

    // Output flop takes the next-state level so it moves on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_out[i] <= 1'b0;
      else        rst_out[i] <= line_level(c_nxt, g_nxt, HAS_GRANT);
    end
  end
endmodule

// File: rtl/keyed_reset_bank.sv
module keyed_reset_bank
  import krb_pkg::*;
#(
  parameter int NUM_LINES             = 24,
  parameter bit HAS_GRANT             = 1'b1,
  parameter int ADDR_W                = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'h18,
  parameter logic [ADDR_W-1:0] GRANT_OFS = 8'hfc,
  parameter logic [7:0] KEY           = 8'h88
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_LINES-1:0] rst_out
);
  localparam int PAD_W = DATA_W - NUM_LINES;

  logic                 sel_ctrl;
  logic                 sel_grant;
  logic                 ctrl_we;
  logic                 grant_we;
  logic [NUM_LINES-1:0] ctrl_q;
  logic [NUM_LINES-1:0] grant_q;

  krb_decode #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .GRANT_OFS(GRANT_OFS),
    .HAS_GRANT(HAS_GRANT), .KEY(KEY)
  ) u_decode (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sel_ctrl(sel_ctrl), .sel_grant(sel_grant),
    .ctrl_we(ctrl_we), .grant_we(grant_we)
  );

  krb_lines #(.NUM_LINES(NUM_LINES), .HAS_GRANT(HAS_GRANT)) u_lines (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .grant_we(grant_we),
    .wr_bits(wdata[NUM_LINES-1:0]),
    .ctrl_q(ctrl_q), .grant_q(grant_q), .rst_out(rst_out)
  );

  always_comb begin
    if (sel_ctrl)       rdata = {{PAD_W{1'b0}}, ctrl_q};
    else if (sel_grant) rdata = {{PAD_W{1'b0}}, grant_q};
    else                rdata = '0;
  end
endmodule

// File: rtl/krb_checker.sv
module krb_checker #(
  parameter int NUM_LINES = 24,
  parameter bit HAS_GRANT = 1'b1,
  parameter int ADDR_W    = 8,
  parameter logic [7:0] KEY = 8'h88
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic [31:0]          rdata,
  input logic [NUM_LINES-1:0] rst_out,
  input logic                 ctrl_we,
  input logic                 grant_we,
  input logic [NUM_LINES-1:0] ctrl_q,
  input logic [NUM_LINES-1:0] grant_q
);
  // R3: wrong key leaves all state alone
  a_r3_badkey_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[31:24] != KEY) |=> ($stable(ctrl_q) && $stable(grant_q) && $stable(rst_out)));

  // R2: accepted line-control write is stored
  a_r2_accept_stores: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata[NUM_LINES-1:0])));

  // R6: outputs hold without an accepted write
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && !grant_we) |=> $stable(rst_out));

  // R7: key byte never read back
  a_r7_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:24] == 8'h00);

  if (HAS_GRANT) begin : g_chk_grant
    // R4/R5: no asserted line without its grant
    a_r5_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_out & ~grant_q) == '0);
  end else begin : g_chk_direct
    // R9: outputs follow stored bits
    a_r9_follows_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out == ctrl_q);
  end
endmodule

bind keyed_reset_bank krb_checker #(
  .NUM_LINES(NUM_LINES), .HAS_GRANT(HAS_GRANT), .ADDR_W(ADDR_W), .KEY(KEY)
) u_chk (.*);

// File: tb/sim_keyed_reset_bank.sv
module sim_keyed_reset_bank;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 0 u0 out, 1 u0 rdata, 2 u1 out, 3 u1 rdata
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [23:0] out0;
  logic [15:0] out1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t q[$];

  logic [23:0] m_ctrl = '0, m_grant = '0;
  logic [15:0] m1_ctrl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_reset_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata0), .rst_out(out0)
  );

  keyed_reset_bank #(.NUM_LINES(16), .HAS_GRANT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata1), .rst_out(out1)
  );

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_outs(string tag);
    push(0, {8'h0, m_ctrl & m_grant}, tag);
    push(2, {16'h0, m1_ctrl}, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    push_outs({tag, " pre-edge R6"});
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (d[31:24] == 8'h88) begin
      if (a == 8'h18) begin m_ctrl = d[23:0]; m1_ctrl = d[15:0]; end
      if (a == 8'hfc) m_grant = d[23:0];
    end
    push_outs(tag);
  endtask

  task automatic rd(logic [7:0] a, int unit_kind, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    push(unit_kind, exp, tag);
  endtask

  // Monitor
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      case (it.kind)
        0:       act = {8'h0, out0};
        1:       act = rdata0;
        2:       act = {16'h0, out1};
        default: act = rdata1;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    push_outs("R1 reset outputs");
    rd(8'h18, 1, 32'h0, "R1 ctrl reads zero");
    rd(8'hfc, 1, 32'h0, "R1 grant reads zero");
    @(negedge clk);
    rst_n = 1'b1;

    wr(8'h18, 32'h8800000F, "R4 assert without grant");
    rd(8'h18, 1, 32'h0000000F, "R2 ctrl readback");
    wr(8'hfc, 32'h88FFFFFF, "R4 grant all");
    rd(8'hfc, 3, 32'h0, "R9 no grant register");
    rd(8'hfc, 1, 32'h00FFFFFF, "R4 grant readback");

    wr(8'h18, 32'h770000F0, "R3 bad key ctrl");
    rd(8'h18, 1, 32'h0000000F, "R3 ctrl unchanged");
    wr(8'hfc, 32'h00000000, "R3 bad key grant");
    rd(8'hfc, 1, 32'h00FFFFFF, "R3 grant unchanged");

    wr(8'h18, 32'h88A5A5A5, "R2 pattern");
    rd(8'h18, 1, 32'h00A5A5A5, "R7 key bits zero");
    rd(8'h18, 3, 32'h0000A5A5, "R7 bits above lines zero");

    wr(8'hfc, 32'h88FFFFFE, "R5 withdraw grant 0");
    rd(8'h18, 1, 32'h00A5A5A5, "R5 ctrl bit kept");

    wr(8'h20, 32'h88FFFFFF, "R8 unmapped write");
    rd(8'h20, 1, 32'h0, "R8 unmapped read");
    rd(8'h20, 3, 32'h0, "R8 unmapped read u1");

    wr(8'h18, 32'h885A5A5A, "R2 inverse pattern");
    wr(8'h18, 32'h88000000, "R2 release all");

    @(negedge clk);
    wait (q.size() == 0);
    #5;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule